// File: doc/BRIEF.md
# Audio Clock Configuration Controller

This block is the digital control front end of a multi-output audio clock generator. It decides which configuration the frequency synthesizer should use: a sampling-group code, a standard or double rate flag, six per-output enable bits, and a multiplier select for the fourth generated clock. The analog loops, the oscillator and the output buffers live elsewhere. This block only presents the settled configuration to them.

Three control pins are shared between two modes, and a mode pin picks the mode. In serial mode the pins act as a latch strobe, a data line and a shift clock. A 16-bit word is shifted in, and a rising edge on the strobe commits it to a configuration register. The word must carry a fixed 6-bit header and legal codes, or it is discarded and an error pulse is raised. In parallel mode the same pins select the group and the rate directly, and every output stays enabled.

All pins are oversampled by the block clock, which is the 27 MHz master clock. Each pin passes through a two-flop synchronizer. The shift clock must toggle no faster than a quarter of the master clock rate. Two reset sources are supported: an external active-low pin and an internal power-on request. Either source restores the defaults, and the defaults are held for a fixed number of master clock cycles after release.

Top module: `clkgen_ctrl`

## Requirements
- R1: A serial word is taken most significant bit first, one bit per rising edge of the shift clock. Bits 15..10 must equal 0,1,1,1,0,0. Bits 9..4 are the enables of outputs 6..1, so `out_en[k-1]` follows bit k+3. Bits 3..2 are the rate code and bits 1..0 are the group code.
- R2: In serial mode, a rising edge on the latch pin commits the last shifted word. The outputs show the new configuration within 4 clock cycles of the edge.
- R3: The group code drives `grp_code` with the same value: 00 is 48 kHz, 01 is 44.1 kHz and 10 is 32 kHz. `grp_code` never shows 11.
- R4: Rate code 00 gives standard rate (`dbl_rate`=0) and rate code 01 gives double rate (`dbl_rate`=1).
- R5: A word whose header is not 011100 is discarded at the latch edge. The outputs keep their previous configuration, and `frame_err` is high for exactly one cycle.
- R6: A word with group code 11, or with rate code 10 or 11, is discarded and flagged in the same way as a bad header.
- R7: When more than 16 bits arrive before the latch edge, only the last 16 bits count.
- R8: In parallel mode, `grp_code` follows {group pin 1, group pin 0} and `dbl_rate` follows the rate pin. All six `out_en` bits are 1. The outputs settle within 4 cycles of a pin change.
- R9: In parallel mode, group pins 11 give `grp_code`=00.
- R10: In parallel mode the serial receiver ignores its pins. A full word and a latch edge sent then leave the serial configuration unchanged, and that configuration is shown again once serial mode returns.
- R11: Either reset source reinitialises the serial configuration. After release, both reset sources force the defaults (all enables 1, `grp_code`=00, standard rate, no `frame_err`) for 1024 clock cycles plus synchronization, whatever the mode pins say.
- R12: `mult4_x384` is 1 (384x multiplier) in double rate and 0 (768x multiplier) in standard rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, also the oversampling clock |
| ext_rst_n | input | 1 | External reset, active low |
| por_n | input | 1 | Internal power-on reset request, active low |
| mode_par | input | 1 | 1 selects parallel mode, 0 selects serial mode |
| pin_lat_sr | input | 1 | Serial: latch strobe; parallel: rate select |
| pin_dat_fs0 | input | 1 | Serial: data; parallel: group bit 0 |
| pin_sck_fs1 | input | 1 | Serial: shift clock; parallel: group bit 1 |
| out_en | output | 6 | Enable of clock outputs 6..1 (bit 5 is output 6) |
| grp_code | output | 2 | Sampling group code |
| dbl_rate | output | 1 | 1 selects double rate |
| mult4_x384 | output | 1 | Fourth output multiplier: 1 is 384x, 0 is 768x |
| frame_err | output | 1 | One-cycle pulse when a latched word is rejected |

## Verification
A pin change reaches the outputs after two synchronizer edges and one output register edge, so parallel results are due on the third rising edge. A latch edge needs one more edge for edge detection and the register update, so serial results are due on the fourth. The bench drives pins on falling edges and checks results six cycles later, well after both latencies. It counts `frame_err` pulses over an eight-cycle window that covers the rejection cycle. Reset release takes 2 synchronizer edges, 1024 hold edges and one output edge. The bench checks that the defaults still hold 1000 cycles after release and that the pin-selected configuration appears by 1040 cycles.

// File: rtl/clkgen_ctrl_pkg.sv
`timescale 1ns/1ps
package clkgen_ctrl_pkg;

  localparam int FRAME_W  = 16;
  localparam int HDR_W    = 6;
  localparam int NUM_OUT  = 6;
  localparam int GRP_W    = 2;

  // field positions inside a serial word
  localparam int HDR_LSB  = FRAME_W - HDR_W;
  localparam int EN_LSB   = 4;
  localparam int RATE_LSB = 2;
  localparam int GRP_LSB  = 0;

  localparam logic [HDR_W-1:0] HDR_CODE = 6'b011100;

  localparam logic [GRP_W-1:0] GRP_48K  = 2'b00;
  localparam logic [GRP_W-1:0] GRP_44K  = 2'b01;
  localparam logic [GRP_W-1:0] GRP_32K  = 2'b10;
  localparam logic [GRP_W-1:0] GRP_RSVD = 2'b11;

  typedef struct packed {
    logic [NUM_OUT-1:0] en;
    logic               dbl;
    logic [GRP_W-1:0]   grp;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{en: '1, dbl: 1'b0, grp: GRP_48K};

  function automatic logic word_ok(input logic [FRAME_W-1:0] w);
    logic hdr_ok;
    logic grp_ok;
    logic rate_ok;
    hdr_ok  = (w[HDR_LSB +: HDR_W] == HDR_CODE);
    grp_ok  = (w[GRP_LSB +: GRP_W] != GRP_RSVD);
    rate_ok = (w[RATE_LSB + 1] == 1'b0);
    return hdr_ok && grp_ok && rate_ok;
  endfunction

  function automatic cfg_t word_cfg(input logic [FRAME_W-1:0] w);
    cfg_t c;
    c.en  = w[EN_LSB +: NUM_OUT];
    c.dbl = w[RATE_LSB];
    c.grp = w[GRP_LSB +: GRP_W];
    return c;
  endfunction

endpackage

// File: rtl/ctl_rst_seq.sv
`timescale 1ns/1ps
module ctl_rst_seq #(
  parameter int HOLD_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic por_n,
  output logic rst_s_n,
  output logic hold
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYCLES);

  logic                   arst_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          cnt_d;

  assign arst_n = ext_rst_n & por_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[SYNC_STAGES-1];
  assign hold    = (cnt_q != HOLD_END);

  always_comb begin
    cnt_d = cnt_q;
    if (hold) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ctl_pin_sync.sv
`timescale 1ns/1ps
module ctl_pin_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] pin_s
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin[g]};
    end
    assign pin_s[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ctl_serial_rx.sv
`timescale 1ns/1ps
module ctl_serial_rx
  import clkgen_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sck,
  input  logic dat,
  input  logic lat,
  output cfg_t cfg,
  output logic err
);

  logic               sck_q, lat_q;
  logic               sck_rise, lat_rise;
  logic [FRAME_W-1:0] sh_q, sh_d;
  cfg_t               cfg_q, cfg_d;
  logic               err_d, err_q;

  // previous-value flops run in every mode so enabling never fakes an edge
  assign sck_rise = en & sck & ~sck_q;
  assign lat_rise = en & lat & ~lat_q;

  always_comb begin
    sh_d  = sh_q;
    cfg_d = cfg_q;
    err_d = 1'b0;
    if (sck_rise) sh_d = {sh_q[FRAME_W-2:0], dat};
    if (lat_rise) begin
      if (word_ok(sh_q)) cfg_d = word_cfg(sh_q);
      else               err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      lat_q <= 1'b0;
      sh_q  <= '0;
      cfg_q <= CFG_DEFAULT;
      err_q <= 1'b0;
    end else begin
      sck_q <= sck;
      lat_q <= lat;
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg = cfg_q;
  assign err = err_q;

endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
  import clkgen_ctrl_pkg::*;
#(
  parameter int HOLD_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               por_n,
  input  logic               mode_par,
  input  logic               pin_lat_sr,
  input  logic               pin_dat_fs0,
  input  logic               pin_sck_fs1,
  output logic [NUM_OUT-1:0] out_en,
  output logic [GRP_W-1:0]   grp_code,
  output logic               dbl_rate,
  output logic               mult4_x384,
  output logic               frame_err
);

  localparam int NPIN = 4;
  localparam int P_SCK = 0, P_DAT = 1, P_LAT = 2, P_MODE = 3;

  logic            rst_s_n;
  logic            hold;
  logic [NPIN-1:0] pins_raw, pins_s;
  logic            par_act;
  logic            ser_en;
  cfg_t            ser_cfg;
  logic            ser_err;
  cfg_t            par_cfg;
  cfg_t            out_d, out_q;
  logic            err_q;

  ctl_rst_seq #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rst (
    .clk       (clk),
    .ext_rst_n (ext_rst_n),
    .por_n     (por_n),
    .rst_s_n   (rst_s_n),
    .hold      (hold)
  );

  assign pins_raw = {mode_par, pin_lat_sr, pin_dat_fs0, pin_sck_fs1};

  ctl_pin_sync #(
    .N      (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .pin   (pins_raw),
    .pin_s (pins_s)
  );

  assign par_act = pins_s[P_MODE] & ~hold;
  assign ser_en  = ~pins_s[P_MODE] & ~hold;

  ctl_serial_rx u_rx (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (ser_en),
    .sck   (pins_s[P_SCK]),
    .dat   (pins_s[P_DAT]),
    .lat   (pins_s[P_LAT]),
    .cfg   (ser_cfg),
    .err   (ser_err)
  );

  // parallel decode: reserved group falls back to the default group
  always_comb begin
    par_cfg.en  = '1;
    par_cfg.dbl = pins_s[P_LAT];
    par_cfg.grp = {pins_s[P_SCK], pins_s[P_DAT]};
    if (par_cfg.grp == GRP_RSVD) par_cfg.grp = GRP_48K;
  end

  always_comb begin
    if (hold)         out_d = CFG_DEFAULT;
    else if (par_act) out_d = par_cfg;
    else              out_d = ser_cfg;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_q <= CFG_DEFAULT;
      err_q <= 1'b0;
    end else begin
      out_q <= out_d;
      err_q <= ser_err;
    end
  end

  assign out_en     = out_q.en;
  assign grp_code   = out_q.grp;
  assign dbl_rate   = out_q.dbl;
  assign mult4_x384 = out_q.dbl;
  assign frame_err  = err_q;

endmodule

// File: rtl/clkgen_ctrl_chk.sv
`timescale 1ns/1ps
module clkgen_ctrl_chk
  import clkgen_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               hold,
  input logic               par_act,
  input cfg_t               cfg_q,
  input logic [NUM_OUT-1:0] out_en,
  input logic [GRP_W-1:0]   grp_code,
  input logic               dbl_rate,
  input logic               frame_err
);

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R5

  AST_ERR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(cfg_q)); // R6

  AST_GRP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    grp_code != GRP_RSVD); // R3

  AST_PAR_ALL_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_act) |-> (&out_en)); // R8

  AST_HOLD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> ((&out_en) && grp_code == GRP_48K && !dbl_rate)); // R11

  AST_HOLD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !frame_err); // R11

endmodule

bind clkgen_ctrl clkgen_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .hold      (hold),
  .par_act   (par_act),
  .cfg_q     (ser_cfg),
  .out_en    (out_en),
  .grp_code  (grp_code),
  .dbl_rate  (dbl_rate),
  .frame_err (frame_err)
);

// File: tb/clkgen_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_ctrl_test;

  logic       clk = 1'b0;
  logic       ext_rst_n, por_n, mode_par;
  logic       pin_lat_sr, pin_dat_fs0, pin_sck_fs1;
  logic [5:0] out_en;
  logic [1:0] grp_code;
  logic       dbl_rate, mult4_x384, frame_err;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // expected configuration model
  logic [5:0] e_en;
  logic [1:0] e_grp;
  logic       e_dbl;

  always #2 clk = ~clk;

  clkgen_ctrl uut (
    .clk         (clk),
    .ext_rst_n   (ext_rst_n),
    .por_n       (por_n),
    .mode_par    (mode_par),
    .pin_lat_sr  (pin_lat_sr),
    .pin_dat_fs0 (pin_dat_fs0),
    .pin_sck_fs1 (pin_sck_fs1),
    .out_en      (out_en),
    .grp_code    (grp_code),
    .dbl_rate    (dbl_rate),
    .mult4_x384  (mult4_x384),
    .frame_err   (frame_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk(req, {22'd0, out_en, grp_code, dbl_rate, mult4_x384},
        {22'd0, e_en, e_grp, e_dbl, e_dbl});
  endtask

  task automatic set_defaults();
    e_en = 6'h3f; e_grp = 2'b00; e_dbl = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      pin_dat_fs0 = bits[i];
      tick(2);
      pin_sck_fs1 = 1'b1;
      tick(3);
      pin_sck_fs1 = 1'b0;
      tick(3);
    end
  endtask

  // raise the latch, count error pulses, return to low
  task automatic latch_word(input string req, input logic exp_err);
    int pulses;
    pulses = 0;
    pin_lat_sr = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (frame_err) pulses++;
    end
    chk(req, pulses, exp_err ? 1 : 0);
    pin_lat_sr = 1'b0;
    tick(3);
  endtask

  function automatic logic word_legal(input logic [15:0] w);
    return (w[15:10] == 6'b011100) && (w[1:0] != 2'b11) && !w[3];
  endfunction

  task automatic serial_word(input string req, input logic [15:0] w);
    logic ok;
    ok = word_legal(w);
    send_bits({16'd0, w}, 16);
    latch_word(req, !ok);
    if (ok) begin
      e_en = w[9:4]; e_dbl = w[2]; e_grp = w[1:0];
    end
    chk_out(req);
  endtask

  task automatic to_serial();
    pin_lat_sr = 1'b0; pin_dat_fs0 = 1'b0; pin_sck_fs1 = 1'b0;
    tick(4);
    mode_par = 1'b0;
    tick(6);
  endtask

  initial begin
    ext_rst_n = 1'b0; por_n = 1'b1; mode_par = 1'b0;
    pin_lat_sr = 1'b0; pin_dat_fs0 = 1'b0; pin_sck_fs1 = 1'b0;
    set_defaults();
    tick(4);
    ext_rst_n = 1'b1;
    tick(5);
    chk_out("R11 reset state");
    chk("R11 no err in hold", {31'd0, frame_err}, 32'd0);
    tick(1040);
    chk_out("R11 defaults after hold");

    // R1 R3 R4 R12: sweep all enable patterns with rotating legal codes
    for (int i = 0; i < 64; i++) begin
      logic [1:0] fs;
      logic       sr;
      fs = 2'(i % 3);
      sr = 1'((i / 3) % 2);
      serial_word("R1 R3 R4 R12 sweep", {6'b011100, 6'(i), 1'b0, sr, fs});
    end

    // R6 R4: every rate/group code combination
    for (int c = 0; c < 16; c++) begin
      serial_word("R6 code sweep", {6'b011100, 6'(6'h2a ^ c), 4'(c)});
    end

    // R5: each header bit flipped in turn
    serial_word("R2 baseline", 16'b011100_110011_00_01);
    for (int b = 10; b < 16; b++) begin
      logic [15:0] w;
      w = 16'b011100_001100_01_10;
      w[b] = ~w[b];
      serial_word("R5 bad header", w);
    end

    // R7: four junk bits ahead of a legal word
    send_bits({12'd0, 4'b1011, 16'b011100_010101_01_10}, 20);
    latch_word("R7 overflow err", 1'b0);
    e_en = 6'b010101; e_dbl = 1'b1; e_grp = 2'b10;
    chk_out("R7 last 16 bits kept");

    // R8 R9: every parallel pin combination
    mode_par = 1'b1;
    for (int p = 0; p < 8; p++) begin
      logic [1:0] fsp;
      pin_lat_sr = p[2]; pin_sck_fs1 = p[1]; pin_dat_fs0 = p[0];
      tick(6);
      fsp = p[1:0];
      chk("R8 parallel enables", {26'd0, out_en}, 32'h3f);
      chk("R9 parallel group", {30'd0, grp_code}, (fsp == 2'b11) ? 32'd0 : {30'd0, fsp});
      chk("R8 R12 parallel rate", {30'd0, dbl_rate, mult4_x384}, {30'd0, p[2], p[2]});
    end

    // R10: a legal word sent in parallel mode is ignored
    pin_lat_sr = 1'b0; pin_dat_fs0 = 1'b0; pin_sck_fs1 = 1'b0;
    tick(4);
    send_bits({16'd0, 16'b011100_111000_00_00}, 16);
    pin_lat_sr = 1'b1;
    tick(6);
    chk("R10 no err in parallel", {31'd0, frame_err}, 32'd0);
    to_serial();
    chk_out("R10 serial cfg retained");

    // R11: external reset with parallel pins asking for 32 kHz double
    mode_par = 1'b1; pin_lat_sr = 1'b1; pin_sck_fs1 = 1'b1; pin_dat_fs0 = 1'b0;
    tick(6);
    ext_rst_n = 1'b0;
    tick(3);
    ext_rst_n = 1'b1;
    set_defaults();
    tick(1000);
    chk_out("R11 ext reset hold");
    tick(40);
    e_grp = 2'b10; e_dbl = 1'b1;
    chk_out("R11 ext reset released");

    // R11: power-on request reinitialises a programmed serial word
    to_serial();
    serial_word("R2 program", 16'b011100_000011_01_01);
    por_n = 1'b0;
    tick(3);
    por_n = 1'b1;
    set_defaults();
    tick(1000);
    chk_out("R11 por hold");
    tick(40);
    chk_out("R11 por register reinit");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule